// File: doc/BRIEF.md
# Lane-to-sample octet remapper

This block sits after the receive deframer of a four-lane serial converter link. It takes one 32-bit word per lane on every link clock, with the lanes already aligned and descrambled. It regroups the octets of those words into 16-bit converter samples. Each sample joins octets that share the same position, either on two neighbouring lanes or within one lane, depending on how many octets a frame spends on each lane.

The mode is fixed when the block is elaborated. With one octet per frame on each lane, a four-step frame counter walks through the octet positions. Each step yields a 32-bit word that holds two samples. These are either two samples of one converter or one sample from each of two converters, and in both readings the low half comes first. With two octets per frame, a two-step counter yields a 64-bit word that holds four samples per frame, so the converter count times the samples per converter must equal 4. When the frame clock is divided down to the link clock, every step is emitted at once in one wide word.

Top module: `lane_octet_remap`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, sample_o is all zero and sample_valid_o is low.
- R2: Lane k occupies lane_data_i[32k+31:32k]. Octet position p of lane k (p = 0 is the earliest octet) occupies bits [32k+31-8p -: 8]. Lane 0 holds F0..F3, lane 1 F4..F7, lane 2 F8..F11 and lane 3 F12..F15.
- R3: With OCT_PER_FRAME=1 and FRAME_DIV=1, the frame counter n runs 0,1,2,3 and then wraps. The word emitted at step n is {F(8+n), F(12+n), F(n), F(4+n)}, from MSB to LSB. In each 16-bit half, the octet from the lower-numbered lane is the upper byte.
- R4: With OCT_PER_FRAME=2 and FRAME_DIV=1, the counter n runs 0,1 and the output is 64 bits wide. Bits [16k+15:16k] hold {octet 2n of lane k, octet 2n+1 of lane k}.
- R5: With FRAME_DIV equal to the number of counter steps (4 for one octet per frame, 2 for two), one output word holds every step. Step 0 sits in the least significant step-sized slice and the last step in the most significant. Each accepted lane word gives exactly one output.
- R6: In the undivided modes, the lane word is captured when the counter is 0. All later steps of the same sequence come from that captured word, and lane data presented at non-zero counts has no effect on the output.
- R7: A cycle is accepted when lane_valid_i and lane_aligned_i are both high. sample_valid_o is high exactly in the cycle after an accepted cycle. The counter advances only on accepted cycles.
- R8: When lane_aligned_i is low, the counter returns to 0 and no output is produced, whatever the state of lane_valid_i.
- R9: While sample_valid_o is low, sample_o keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lane_data_i | input | 128 | Four aligned lane words, lane 0 in the low 32 bits |
| lane_valid_i | input | 1 | Lane words valid this cycle |
| lane_aligned_i | input | 1 | Lanes aligned; low clears the frame counter |
| sample_o | output | OUT_W (32·OCT_PER_FRAME·FRAME_DIV) | Remapped sample word |
| sample_valid_o | output | 1 | sample_o carries a new word |

## Verification
The assertions assume that lane_valid_i and lane_aligned_i are two-state after reset. They also assume that loss of alignment may arrive at any counter value, including in the middle of a sequence. The bench drives all inputs at the falling edge with known values. Each mode is run with back-to-back valids, with valid gaps, with new data on every cycle so that the hold rule is tested, and with alignment dropped at each of the four counter positions. This keeps the stimulus inside those assumptions while still reaching every counter state.

// File: rtl/lane_remap_pkg.sv
`timescale 1ns/1ps
package lane_remap_pkg;
  localparam int unsigned NUM_LANES = 4;
  localparam int unsigned LANE_W    = 32;
  localparam int unsigned BUS_W     = NUM_LANES * LANE_W;

  // position 0 is the earliest octet, in the most significant byte of the lane
  function automatic logic [7:0] lane_octet(input logic [BUS_W-1:0] bus,
                                            input int unsigned lane,
                                            input int unsigned pos);
    return bus[lane*LANE_W + LANE_W - 1 - pos*8 -: 8];
  endfunction
endpackage

// File: rtl/remap_frame_ctr.sv
`timescale 1ns/1ps
module remap_frame_ctr #(
  parameter int unsigned STEPS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  input  logic       aligned_i,
  output logic [1:0] step_o
);
  localparam logic [1:0] LAST = 2'(STEPS - 1);

  logic [1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         step_q <= 2'd0;
    else if (!aligned_i) step_q <= 2'd0;
    else if (adv_i)      step_q <= (step_q == LAST) ? 2'd0 : step_q + 2'd1;
  end

  assign step_o = step_q;

  // R8
  ctr_unalign_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aligned_i |=> step_q == 2'd0);
  // R7
  ctr_idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aligned_i && !adv_i |=> $stable(step_q));
  // R3
  ctr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= LAST);
  // R3
  ctr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aligned_i && adv_i && step_q == LAST |=> step_q == 2'd0);
endmodule

// File: rtl/remap_lane_hold.sv
`timescale 1ns/1ps
module remap_lane_hold #(
  parameter int unsigned W = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_o <= '0;
    else if (load_i) data_o <= data_i;
  end
endmodule

// File: rtl/remap_step_map.sv
`timescale 1ns/1ps
module remap_step_map
  import lane_remap_pkg::*;
#(
  parameter int unsigned OCT_PER_FRAME = 1,
  localparam int unsigned STEP_W = 32 * OCT_PER_FRAME
) (
  input  logic [BUS_W-1:0]  lanes_i,
  input  logic [1:0]        step_i,
  output logic [STEP_W-1:0] word_o
);
  generate
    if (OCT_PER_FRAME == 1) begin : g_one
      // pair same-position octets of lanes 0/1 and 2/3, lower lane in upper byte
      always_comb begin
        word_o = {lane_octet(lanes_i, 2, int'(step_i)), lane_octet(lanes_i, 3, int'(step_i)),
                  lane_octet(lanes_i, 0, int'(step_i)), lane_octet(lanes_i, 1, int'(step_i))};
      end
    end else begin : g_two
      always_comb begin
        for (int l = 0; l < NUM_LANES; l++) begin
          word_o[16*l +: 16] = {lane_octet(lanes_i, l, 2*int'(step_i)),
                                lane_octet(lanes_i, l, 2*int'(step_i) + 1)};
        end
      end
    end
  endgenerate
endmodule

// File: rtl/lane_octet_remap.sv
`timescale 1ns/1ps
module lane_octet_remap
  import lane_remap_pkg::*;
#(
  parameter int unsigned OCT_PER_FRAME = 1,
  parameter int unsigned FRAME_DIV     = 1,
  localparam int unsigned STEPS  = 4 / OCT_PER_FRAME,
  localparam int unsigned STEP_W = 32 * OCT_PER_FRAME,
  localparam int unsigned OUT_W  = STEP_W * FRAME_DIV
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BUS_W-1:0] lane_data_i,
  input  logic             lane_valid_i,
  input  logic             lane_aligned_i,
  output logic [OUT_W-1:0] sample_o,
  output logic             sample_valid_o
);
  logic             accept;
  logic [OUT_W-1:0] next_word;

  assign accept = lane_valid_i && lane_aligned_i;

  generate
    if (FRAME_DIV == 1) begin : g_step
      logic [1:0]       step;
      logic [BUS_W-1:0] held;
      logic [BUS_W-1:0] src;

      remap_frame_ctr #(.STEPS(STEPS)) ctr_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .adv_i    (lane_valid_i),
        .aligned_i(lane_aligned_i),
        .step_o   (step)
      );

      remap_lane_hold #(.W(BUS_W)) hold_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .load_i(accept && step == 2'd0),
        .data_i(lane_data_i),
        .data_o(held)
      );

      // step 0 maps the live word; later steps map the captured copy
      assign src = (step == 2'd0) ? lane_data_i : held;

      remap_step_map #(.OCT_PER_FRAME(OCT_PER_FRAME)) map_i (
        .lanes_i(src),
        .step_i (step),
        .word_o (next_word)
      );
    end else begin : g_wide
      for (genvar s = 0; s < STEPS; s++) begin : g_slice
        remap_step_map #(.OCT_PER_FRAME(OCT_PER_FRAME)) map_i (
          .lanes_i(lane_data_i),
          .step_i (2'(s)),
          .word_o (next_word[s*STEP_W +: STEP_W])
        );
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o       <= '0;
      sample_valid_o <= 1'b0;
    end else begin
      sample_valid_o <= accept;
      if (accept) sample_o <= next_word;
    end
  end

  // R7
  out_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_valid_i && lane_aligned_i |=> sample_valid_o);
  // R8
  out_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lane_aligned_i |=> !sample_valid_o);
  // R9
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_o |-> $stable(sample_o));
endmodule

// File: tb/lane_octet_remap_tb.sv
`timescale 1ns/1ps
module lane_octet_remap_tb_top;
  localparam int NCFG = 4;
  localparam int CF[NCFG] = '{1, 1, 2, 2};
  localparam int CD[NCFG] = '{1, 4, 1, 2};

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [127:0] lane_data = '0;
  logic         lane_valid = 1'b0;
  logic         lane_aligned = 1'b0;

  logic [31:0]  out0;
  logic [127:0] out1;
  logic [63:0]  out2;
  logic [127:0] out3;
  logic [NCFG-1:0] vld;

  int checks = 0;
  int errors = 0;

  logic [127:0] exp_data[NCFG];
  bit           exp_vld[NCFG];
  int           cnt_m[NCFG];
  logic [127:0] hold_m[NCFG];
  int           exp_step[NCFG];
  bit           prev_unaligned;

  always #2.5 clk_i = ~clk_i;

  lane_octet_remap #(.OCT_PER_FRAME(1), .FRAME_DIV(1)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .lane_data_i(lane_data), .lane_valid_i(lane_valid),
    .lane_aligned_i(lane_aligned), .sample_o(out0), .sample_valid_o(vld[0]));
  lane_octet_remap #(.OCT_PER_FRAME(1), .FRAME_DIV(4)) dut_d4_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .lane_data_i(lane_data), .lane_valid_i(lane_valid),
    .lane_aligned_i(lane_aligned), .sample_o(out1), .sample_valid_o(vld[1]));
  lane_octet_remap #(.OCT_PER_FRAME(2), .FRAME_DIV(1)) dut_f2_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .lane_data_i(lane_data), .lane_valid_i(lane_valid),
    .lane_aligned_i(lane_aligned), .sample_o(out2), .sample_valid_o(vld[2]));
  lane_octet_remap #(.OCT_PER_FRAME(2), .FRAME_DIV(2)) dut_f2d2_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .lane_data_i(lane_data), .lane_valid_i(lane_valid),
    .lane_aligned_i(lane_aligned), .sample_o(out3), .sample_valid_o(vld[3]));

  function automatic logic [127:0] got(input int c);
    case (c)
      0: return {96'b0, out0};
      1: return out1;
      2: return {64'b0, out2};
      default: return out3;
    endcase
  endfunction

  // R2: octet p of lane k at bits [32k+31-8p -: 8]
  function automatic logic [7:0] oct(input logic [127:0] d, input int k, input int p);
    return d[32*k + 31 - 8*p -: 8];
  endfunction

  function automatic logic [63:0] step_word(input logic [127:0] d, input int n, input int f);
    logic [63:0] r;
    r = '0;
    if (f == 1) r[31:0] = {oct(d, 2, n), oct(d, 3, n), oct(d, 0, n), oct(d, 1, n)};
    else for (int k = 0; k < 4; k++) r[16*k +: 16] = {oct(d, k, 2*n), oct(d, k, 2*n + 1)};
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp, input int c);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cfg%0d actual=%h expected=%h", tag, c, act, exp);
    end
  endtask

  task automatic model(input logic [127:0] d, input bit v, input bit a);
    for (int c = 0; c < NCFG; c++) begin
      int steps;
      steps = 4 / CF[c];
      if (!a) begin
        cnt_m[c] = 0;
        exp_vld[c] = 0;
      end else if (!v) begin
        exp_vld[c] = 0;
      end else if (CD[c] == 1) begin
        if (cnt_m[c] == 0) hold_m[c] = d;
        exp_data[c] = 128'(step_word(hold_m[c], cnt_m[c], CF[c]));
        exp_step[c] = cnt_m[c];
        cnt_m[c] = (cnt_m[c] + 1) % steps;
        exp_vld[c] = 1;
      end else begin
        exp_data[c] = '0;
        for (int s = 0; s < steps; s++)
          exp_data[c] |= 128'(step_word(d, s, CF[c])) << (s * 32 * CF[c]);
        exp_vld[c] = 1;
      end
    end
  endtask

  task automatic verify();
    for (int c = 0; c < NCFG; c++) begin
      string tag;
      tag = prev_unaligned ? "R8" : "R7";
      check(vld[c] == exp_vld[c], tag, 128'(vld[c]), 128'(exp_vld[c]), c);
      if (exp_vld[c]) begin
        if (CD[c] != 1) tag = "R2/R5";
        else if (exp_step[c] != 0) tag = (CF[c] == 1) ? "R3/R6" : "R4/R6";
        else tag = (CF[c] == 1) ? "R2/R3" : "R2/R4";
      end else tag = "R9";
      check(got(c) == exp_data[c], tag, got(c), exp_data[c], c);
    end
  endtask

  task automatic cycle(input logic [127:0] d, input bit v, input bit a);
    @(negedge clk_i);
    lane_data = d;
    lane_valid = v;
    lane_aligned = a;
    model(d, v, a);
    @(posedge clk_i);
    #1;
    verify();
    prev_unaligned = !a;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] idx;
    for (int c = 0; c < NCFG; c++) begin
      exp_data[c] = '0; exp_vld[c] = 0; cnt_m[c] = 0; hold_m[c] = '0; exp_step[c] = 0;
    end
    prev_unaligned = 0;
    repeat (3) @(posedge clk_i);
    #1;
    // R1: in reset
    for (int c = 0; c < NCFG; c++) begin
      check(got(c) == '0, "R1", got(c), '0, c);
      check(vld[c] == 1'b0, "R1", 128'(vld[c]), '0, c);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    // R1: first cycle out of reset
    for (int c = 0; c < NCFG; c++) begin
      check(got(c) == '0, "R1", got(c), '0, c);
      check(vld[c] == 1'b0, "R1", 128'(vld[c]), '0, c);
    end

    // R2: octet index pattern, byte value = F number
    for (int k = 0; k < 4; k++)
      for (int p = 0; p < 4; p++) idx[32*k + 31 - 8*p -: 8] = 8'(4*k + p);
    repeat (8) cycle(idx, 1, 1);

    // R3 R4 R5 R6: back-to-back, fresh data every cycle
    repeat (48) cycle(rnd128(), 1, 1);

    // R7 R9: valid gaps
    for (int i = 0; i < 60; i++) cycle(rnd128(), (i % 3) != 0, 1);

    // R8: drop alignment at every counter position, with and without valid
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < k; i++) cycle(rnd128(), 1, 1);
      cycle(rnd128(), 1, 0);
      cycle(rnd128(), 0, 0);
      repeat (6) cycle(rnd128(), 1, 1);
    end

    // R2: walking one across the whole bus
    for (int b = 0; b < 128; b++) cycle(128'(1) << b, 1, 1);

    repeat (2) cycle('0, 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule